// File: doc/BRIEF.md
# Acknowledge-Paced Parallel Bus Master

This block is the master end of a single-byte parallel bus transfer whose pace is set by the addressed device rather than by a fixed cycle count. The CPU side hands it an address, a direction and, for writes, a data byte. The block presents the address and turns the shared auxiliary line into an input. It then drops the read or write strobe, waits a programmable settling interval, and drops the device-select. After that it follows the device's acknowledge line through a four-phase handshake. For a read, the byte on the data bus is captured when the device reports completion, and the requester gets it back together with a one-cycle done pulse.

A programmable maximum-wait count guards both waiting phases. If the device does not answer within that many cycles, the block releases the strobe and the select together, sets a sticky interrupt and refuses new work until the CPU clears it. A maximum-wait value of zero turns the guard off. The acknowledge input is asynchronous to the block clock and passes through a two-flop synchronizer before the state machine sees it.

The state machine has six states. IDLE accepts a request (IDLE to SETUP). SETUP presents the address with both strobes still high and always moves to STROBE. STROBE holds the strobe and moves to WAIT_HI once the settle count is reached. WAIT_HI waits for the acknowledge to go high: it moves to WAIT_LO when the acknowledge is seen high, or back to IDLE on a timeout. WAIT_LO has the strobe released and waits for the acknowledge to go low: it moves to FINISH when the acknowledge is seen low, or to IDLE on a timeout. FINISH releases the select, pulses done and returns to IDLE.

Top module: `hsb_bus_master`

## Requirements
- R1: After reset, bus_rd_n, bus_wr_n and bus_sel_n are high, while irq, done_pulse, bus_dout_en and ack_pin_in are low and req_ready is high.
- R2: A request is taken on a clock edge where req_valid and req_ready are both high. In the following cycle bus_addr equals the request address and ack_pin_in is high, while both strobes and bus_sel_n are still high.
- R3: A read lowers only bus_rd_n and a write lowers only bus_wr_n. bus_sel_n falls exactly cfg_settle+1 cycles after the strobe falls, while the strobe is still low.
- R4: bus_rd_n and bus_wr_n are never low in the same cycle.
- R5: bus_ack is used only after two flops. The strobe rises on the third clock edge after bus_ack rises. For a read, rd_data holds the byte that was on bus_din at that edge.
- R6: bus_sel_n rises only after the strobe has risen. On a completed transfer it rises on the third clock edge after bus_ack falls.
- R7: done_pulse is high for exactly one cycle per completed transfer, in the cycle where bus_sel_n returns high.
- R8: For a write, bus_dout carries the request data and bus_dout_en is high from SETUP until bus_sel_n is released. bus_dout_en is low for reads and whenever no transfer is active.
- R9: When cfg_max_wait is M (not zero) and a waiting phase sees no matching acknowledge level within M cycles, bus_sel_n and both strobes are high in the next cycle, irq goes high and no done_pulse is given.
- R10: A cfg_max_wait of zero disables the timeout, so a device answering after any delay still completes.
- R11: irq stays high until irq_clr is pulsed. While irq is high, req_ready is low and req_valid has no effect on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request from the CPU side |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Transfer address |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | High when a request can be taken (idle and no pending interrupt) |
| cfg_settle | input | SW | Address-settling cycles between strobe and select |
| cfg_max_wait | input | TW | Maximum cycles per waiting phase, 0 = no limit |
| done_pulse | output | 1 | One-cycle completion pulse |
| rd_data | output | DW | Last byte read |
| irq | output | 1 | Sticky timeout interrupt |
| irq_clr | input | 1 | Clears the interrupt |
| bus_addr | output | AW | Address driven onto the bus |
| bus_dout | output | DW | Write data driven onto the bus |
| bus_dout_en | output | 1 | Enable for the data-bus output buffer |
| bus_din | input | DW | Data bus input |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_sel_n | output | 1 | Active-low device select |
| bus_ack | input | 1 | Device acknowledge, high = finished, low = busy |
| ack_pin_in | output | 1 | High while the auxiliary line is configured as an acknowledge input |

## Verification
The assertions assume that cfg_settle and cfg_max_wait stay constant for the length of a transfer. They also assume that bus_ack is low whenever bus_sel_n is high, because the device's buffer pulls it down until the select enables the device. The bench's device model holds the acknowledge low whenever it is not selected. It changes the acknowledge and bus_din only on falling clock edges, and it keeps the read byte on bus_din until the acknowledge drops. In successful sweeps the device delays stay well inside the maximum-wait window. Timeouts are provoked only by a device that never raises the acknowledge or never lowers it.

// File: rtl/hsb_pkg.sv
package hsb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SETUP   = 3'd1,
        ST_STROBE  = 3'd2,
        ST_WAIT_HI = 3'd3,
        ST_WAIT_LO = 3'd4,
        ST_FINISH  = 3'd5
    } hsb_state_t;

endpackage

// File: rtl/hsb_ack_sync.sv
module hsb_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_raw,
    output logic ack_sync
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], ack_raw};
        end
    end

    assign ack_sync = chain_q[STAGES-1];

endmodule

// File: rtl/hsb_state_cnt.sv
module hsb_state_cnt #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] CNT_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/hsb_xfer_fsm.sv
module hsb_xfer_fsm
    import hsb_pkg::*;
#(
    parameter int SW = 4,
    parameter int TW = 8,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          is_write,
    input  logic          ack_s,
    input  logic [CW-1:0] cnt,
    input  logic [SW-1:0] settle,
    input  logic [TW-1:0] max_wait,
    output logic          cnt_clr,
    output logic          rd_n,
    output logic          wr_n,
    output logic          sel_n,
    output logic          dout_en,
    output logic          aux_in,
    output logic          done,
    output logic          abort,
    output logic          capture
);
    hsb_state_t state_q, state_n;

    logic          wait_ph;
    logic          expire;
    logic          settle_hit;
    logic [CW-1:0] lim_m1;

    assign wait_ph    = (state_q == ST_WAIT_HI) || (state_q == ST_WAIT_LO);
    assign lim_m1     = CW'(max_wait) - CW'(1);
    assign expire     = wait_ph && (max_wait != '0) && (cnt == lim_m1);
    assign settle_hit = (cnt == CW'(settle));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_n = ST_SETUP;
            ST_SETUP:   state_n = ST_STROBE;
            ST_STROBE:  if (settle_hit) state_n = ST_WAIT_HI;
            ST_WAIT_HI: begin
                if (ack_s)       state_n = ST_WAIT_LO;
                else if (expire) state_n = ST_IDLE;
            end
            ST_WAIT_LO: begin
                if (!ack_s)      state_n = ST_FINISH;
                else if (expire) state_n = ST_IDLE;
            end
            ST_FINISH:  state_n = ST_IDLE;
            default:    state_n = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rd_n    = 1'b1;
        wr_n    = 1'b1;
        sel_n   = 1'b1;
        dout_en = 1'b0;
        aux_in  = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SETUP: begin
                aux_in  = 1'b1;
                dout_en = is_write;
            end
            ST_STROBE: begin
                aux_in  = 1'b1;
                dout_en = is_write;
                rd_n    = is_write;
                wr_n    = !is_write;
            end
            ST_WAIT_HI: begin
                aux_in  = 1'b1;
                dout_en = is_write;
                rd_n    = is_write;
                wr_n    = !is_write;
                sel_n   = 1'b0;
            end
            ST_WAIT_LO: begin
                aux_in  = 1'b1;
                dout_en = is_write;
                sel_n   = 1'b0;
            end
            ST_FINISH: done = 1'b1;
            default: ;
        endcase
    end

    assign cnt_clr = (state_n != state_q);
    assign capture = (state_q == ST_WAIT_HI) && ack_s;
    assign abort   = expire && (((state_q == ST_WAIT_HI) && !ack_s) ||
                                ((state_q == ST_WAIT_LO) && ack_s));

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R3
    sel_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sel_n) |-> ((!rd_n || !wr_n) && $past(!rd_n || !wr_n)));

    // R6
    sel_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_n) |-> (rd_n && wr_n));

    // R6
    finish_ack_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FINISH) |-> $past(!ack_s));

    // R9
    wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_ph && (max_wait != '0)) |-> (cnt < CW'(max_wait)));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/hsb_bus_master.sv
module hsb_bus_master
    import hsb_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int SW = 4,
    parameter int TW = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    input  logic [SW-1:0] cfg_settle,
    input  logic [TW-1:0] cfg_max_wait,
    output logic          done_pulse,
    output logic [DW-1:0] rd_data,
    output logic          irq,
    input  logic          irq_clr,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_dout,
    output logic          bus_dout_en,
    input  logic [DW-1:0] bus_din,
    output logic          bus_rd_n,
    output logic          bus_wr_n,
    output logic          bus_sel_n,
    input  logic          bus_ack,
    output logic          ack_pin_in
);
    localparam int CW = (SW > TW) ? SW : TW;

    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdat_q;
    logic [DW-1:0] rdat_q;
    logic          dir_q;
    logic          irq_q;
    logic          ack_s;
    logic          cnt_clr;
    logic [CW-1:0] cnt;
    logic          idle;
    logic          start;
    logic          abort;
    logic          capture;
    logic          sel_n_w;

    hsb_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .ack_raw  (bus_ack),
        .ack_sync (ack_s)
    );

    hsb_state_cnt #(.CW(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .cnt   (cnt)
    );

    hsb_xfer_fsm #(.SW(SW), .TW(TW), .CW(CW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .is_write (dir_q),
        .ack_s    (ack_s),
        .cnt      (cnt),
        .settle   (cfg_settle),
        .max_wait (cfg_max_wait),
        .cnt_clr  (cnt_clr),
        .rd_n     (bus_rd_n),
        .wr_n     (bus_wr_n),
        .sel_n    (sel_n_w),
        .dout_en  (bus_dout_en),
        .aux_in   (ack_pin_in),
        .done     (done_pulse),
        .abort    (abort),
        .capture  (capture)
    );

    assign idle      = ack_pin_in == 1'b0 && sel_n_w && !done_pulse;
    assign req_ready = idle && !irq_q;
    assign start     = req_valid && req_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            wdat_q <= '0;
            dir_q  <= 1'b0;
        end else if (start) begin
            addr_q <= req_addr;
            wdat_q <= req_wdata;
            dir_q  <= req_write;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdat_q <= '0;
        end else if (capture && !dir_q) begin
            rdat_q <= bus_din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (abort) begin
            irq_q <= 1'b1;
        end else if (irq_clr) begin
            irq_q <= 1'b0;
        end
    end

    assign bus_addr  = addr_q;
    assign bus_dout  = wdat_q;
    assign bus_sel_n = sel_n_w;
    assign rd_data   = rdat_q;
    assign irq       = irq_q;

    // R11
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);

    // R11
    irq_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !req_ready);

    // R9
    abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (irq && bus_sel_n && bus_rd_n && bus_wr_n && !done_pulse));

endmodule

// File: tb/hsb_bus_master_test.sv
module hsb_bus_master_test;
    localparam int AW = 16;
    localparam int DW = 8;
    localparam int SW = 4;
    localparam int TW = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n;
    logic          req_valid, req_write, req_ready;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata;
    logic [SW-1:0] cfg_settle;
    logic [TW-1:0] cfg_max_wait;
    logic          done_pulse, irq, irq_clr;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_dout;
    logic          bus_dout_en;
    logic [DW-1:0] bus_din;
    logic          bus_rd_n, bus_wr_n, bus_sel_n, ack_pin_in;
    logic          bus_ack;

    hsb_bus_master #(.AW(AW), .DW(DW), .SW(SW), .TW(TW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .cfg_settle(cfg_settle), .cfg_max_wait(cfg_max_wait),
        .done_pulse(done_pulse), .rd_data(rd_data), .irq(irq), .irq_clr(irq_clr),
        .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_dout_en(bus_dout_en),
        .bus_din(bus_din), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
        .bus_sel_n(bus_sel_n), .bus_ack(bus_ack), .ack_pin_in(ack_pin_in)
    );

    int total = 0;
    int bad   = 0;

    task automatic chk(input bit ok, input string r, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
        return DW'(a * 37 + 90) ^ DW'(a >> 8);
    endfunction

    // device configuration and state
    int  hi_dly = 0, lo_dly = 0;
    bit  silent = 0, stuck = 0;
    int  dph = 0, dcnt = 0;
    logic [DW-1:0] wcap = '0;
    int  ack_rise = -100, ack_fall = -100;

    // monitor state
    int  cyc = 0;
    bit  wd_hit = 0;
    bit  exp_den = 0;
    bit  p_str = 1, p_sel = 1;
    int  strobe_fall, strobe_rise, sel_fall, sel_rise;
    int  sel_low_n, strobe_low_n, rd_low_n, wr_low_n, both_low;
    int  done_n, done_cyc, den_bad;

    task automatic clear_stats();
        strobe_fall = -100; strobe_rise = -100; sel_fall = -100; sel_rise = -100;
        sel_low_n = 0; strobe_low_n = 0; rd_low_n = 0; wr_low_n = 0; both_low = 0;
        done_n = 0; done_cyc = -100; den_bad = 0;
        ack_rise = -100; ack_fall = -100;
    endtask

    always @(negedge clk) begin
        bit str_hi;
        cyc++;
        if (cyc > 150000 && !wd_hit) begin
            wd_hit = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
        str_hi = bus_rd_n && bus_wr_n;
        if (!str_hi) strobe_low_n++;
        if (!bus_rd_n) rd_low_n++;
        if (!bus_wr_n) wr_low_n++;
        if (!bus_rd_n && !bus_wr_n) both_low++;
        if (p_str && !str_hi) strobe_fall = cyc;
        if (!p_str && str_hi) strobe_rise = cyc;
        if (p_sel && !bus_sel_n) sel_fall = cyc;
        if (!p_sel && bus_sel_n) sel_rise = cyc;
        if (!bus_sel_n) sel_low_n++;
        if (done_pulse) begin
            done_n++;
            done_cyc = cyc;
        end
        if (!bus_sel_n && (bus_dout_en != exp_den)) den_bad++;
        if (!ack_pin_in && bus_dout_en) den_bad++;
        if (bus_dout_en && bus_dout != req_wdata) den_bad++;
        p_str = str_hi;
        p_sel = bus_sel_n;
        // device model
        if (bus_sel_n) begin
            bus_ack = 1'b0;
            dph = 0;
            dcnt = 0;
        end else if (dph == 0) begin
            if (!silent && dcnt == hi_dly) begin
                bus_ack = 1'b1;
                ack_rise = cyc;
                dph = 1;
                dcnt = 0;
                if (!bus_wr_n) wcap = bus_dout;
                if (!bus_rd_n) bus_din = pat(bus_addr);
            end else begin
                dcnt++;
            end
        end else if (dph == 1) begin
            if (str_hi) begin
                if (!stuck && dcnt == lo_dly) begin
                    bus_ack = 1'b0;
                    ack_fall = cyc;
                    bus_din = '0;
                    dph = 2;
                end else begin
                    dcnt++;
                end
            end
        end
    end

    task automatic xfer(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input int st, input int mw, input int hi, input int lo,
                        input bit sil, input bit stk);
        @(posedge clk); #2;
        cfg_settle = SW'(st);
        cfg_max_wait = TW'(mw);
        hi_dly = hi; lo_dly = lo; silent = sil; stuck = stk;
        exp_den = wr;
        clear_stats();
        req_valid = 1'b1;
        req_write = wr;
        req_addr = a;
        req_wdata = d;
        @(posedge clk); #2;
        req_valid = 1'b0;
        @(negedge clk); #1;
        // R2: address and acknowledge input mode before any strobe
        chk(ack_pin_in == 1'b1 && bus_sel_n && bus_rd_n && bus_wr_n && bus_addr == a,
            "R2 setup phase", int'(bus_addr), int'(a));
        for (int n = 0; n < 400; n++) begin
            @(posedge clk); #2;
            if (done_n > 0 || irq) break;
        end
        repeat (3) @(posedge clk);
        #2;
    endtask

    initial begin
        rst_n = 1'b0;
        req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        cfg_settle = '0; cfg_max_wait = '0; irq_clr = 1'b0;
        bus_din = '0; bus_ack = 1'b0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk); #1;
        // R1
        chk(bus_rd_n && bus_wr_n && bus_sel_n && !irq && !done_pulse && !bus_dout_en
            && !ack_pin_in && req_ready, "R1 reset state",
            {bus_rd_n, bus_wr_n, bus_sel_n, irq, done_pulse, bus_dout_en, ack_pin_in, req_ready},
            8'b1110_0001);

        // sweep: settle x direction x device delays
        for (int st = 0; st < 4; st++) begin
            for (int wr = 0; wr < 2; wr++) begin
                for (int hi = 0; hi < 4; hi++) begin
                    for (int lo = 0; lo < 3; lo++) begin
                        logic [AW-1:0] a;
                        logic [DW-1:0] d;
                        a = AW'(st * 4099 + hi * 257 + lo * 31 + wr * 7001 + 256);
                        d = DW'(a * 5 + st);
                        xfer(wr[0], a, d, st, 40, hi, lo, 1'b0, 1'b0);
                        // R3
                        chk(sel_fall - strobe_fall == st + 1, "R3 settle interval",
                            sel_fall - strobe_fall, st + 1);
                        chk(wr ? (wr_low_n > 0 && rd_low_n == 0) : (rd_low_n > 0 && wr_low_n == 0),
                            "R3 strobe direction", wr ? wr_low_n : rd_low_n, 1);
                        // R4
                        chk(both_low == 0, "R4 strobe exclusion", both_low, 0);
                        // R5
                        chk(strobe_rise - ack_rise == 3, "R5 ack-high to strobe release",
                            strobe_rise - ack_rise, 3);
                        if (wr == 0)
                            chk(rd_data == pat(a), "R5 read data", int'(rd_data), int'(pat(a)));
                        // R6
                        chk(sel_rise - ack_fall == 3 && sel_rise > strobe_rise,
                            "R6 select release", sel_rise - ack_fall, 3);
                        // R7
                        chk(done_n == 1 && done_cyc == sel_rise, "R7 done pulse",
                            done_cyc - sel_rise + 100 * (done_n - 1), 0);
                        // R8
                        chk(den_bad == 0, "R8 data drive window", den_bad, 0);
                        if (wr == 1)
                            chk(wcap == d, "R8 write data", int'(wcap), int'(d));
                        chk(irq == 1'b0, "R9 no spurious irq", int'(irq), 0);
                    end
                end
            end
        end

        // R9: device never acknowledges
        for (int k = 0; k < 3; k++) begin
            int mw;
            mw = (k == 0) ? 1 : (k == 1) ? 2 : 5;
            xfer(1'b0, AW'(16'h1234 + k), 8'h00, 1, mw, 0, 0, 1'b1, 1'b0);
            chk(sel_low_n == mw, "R9 wait-high limit", sel_low_n, mw);
            chk(irq == 1'b1 && done_n == 0, "R9 irq raised", int'(irq) + 2 * done_n, 1);
            chk(strobe_rise == sel_rise, "R9 strobes and select released together",
                sel_rise - strobe_rise, 0);
            if (k == 0) begin
                // R11: requests ignored while irq pending
                clear_stats();
                req_valid = 1'b1;
                req_write = 1'b0;
                repeat (6) @(posedge clk);
                #2;
                chk(req_ready == 1'b0, "R11 ready low while pending", int'(req_ready), 0);
                chk(strobe_low_n == 0 && sel_low_n == 0 && !ack_pin_in,
                    "R11 request ignored", strobe_low_n + sel_low_n, 0);
                chk(irq == 1'b1, "R11 irq held", int'(irq), 1);
                req_valid = 1'b0;
            end
            irq_clr = 1'b1;
            @(posedge clk); #2;
            irq_clr = 1'b0;
            chk(irq == 1'b0 && req_ready == 1'b1, "R11 clear", int'(irq), 0);
        end

        // R9: device never drops its acknowledge
        xfer(1'b1, 16'hBEEF, 8'hA5, 2, 4, 1, 0, 1'b0, 1'b1);
        chk(sel_rise - strobe_rise == 4, "R9 wait-low limit", sel_rise - strobe_rise, 4);
        chk(irq == 1'b1 && done_n == 0, "R9 irq after wait-low", int'(irq) + 2 * done_n, 1);
        irq_clr = 1'b1;
        @(posedge clk); #2;
        irq_clr = 1'b0;

        // R10: limit zero, slow device
        xfer(1'b0, 16'h0F0F, 8'h00, 0, 0, 70, 2, 1'b0, 1'b0);
        chk(done_n == 1 && irq == 1'b0, "R10 no timeout", done_n + 2 * int'(irq), 1);
        chk(rd_data == pat(16'h0F0F), "R10 slow read data", int'(rd_data), int'(pat(16'h0F0F)));

        // R5: transfer after a cleared interrupt works normally
        xfer(1'b0, 16'h00C3, 8'h00, 3, 20, 2, 1, 1'b0, 1'b0);
        chk(done_n == 1 && rd_data == pat(16'h00C3), "R5 read after clear",
            int'(rd_data), int'(pat(16'h00C3)));

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule